// File: doc/BRIEF.md
# Double-to-Single Rounding Converter

This block takes a double-precision operand and rounds it to single precision. The result is still written in the 64-bit double layout. Alongside the result it produces an updated image of the floating-point status word. That image holds four sticky exception flags, a bit that shows the rounding incremented the significand, a bit that shows the result is inexact, and a five-bit result class code. The rounding mode and the three trap enables (overflow, underflow, invalid) are inputs. The block reads them and never changes them.

The operand falls into one of seven cases: zero, infinity, quiet NaN, signalling NaN, in-range finite, overflow or tiny. In-range finite values are rounded at the single-precision boundary using guard, round and sticky bits. When a trap is enabled, an out-of-range value is returned with its exponent moved by 192 toward the representable range. When the trap is disabled, the value is saturated according to the rounding mode, or denormalised.

Each operand accepted with `in_valid` produces registered outputs and `out_valid` one clock later. Between accepted operands the outputs hold their last values.

Top module: `dbl_to_sgl_round`

## Requirements
- R1: After reset `out_valid`, `result`, `flags_out`, `frac_rounded`, `frac_inexact` and `class_out` are all zero. An operand taken with `in_valid` at one rising edge appears on the outputs, with `out_valid` high, right after that edge. `out_valid` falls again on the next edge that has no `in_valid`.
- R2: A zero or infinity operand is returned unchanged, with `frac_rounded` and `frac_inexact` cleared. The class code is 5'b00010 for +0, 5'b10010 for -0, 5'b00101 for +inf and 5'b01001 for -inf.
- R3: A quiet NaN (exponent all ones, fraction MSB set) returns operand bits 63..29 with bits 28..0 zero and class 5'b10001. A signalling NaN sets `flags_out[3]`. If `inv_trap_en` is 0, the NaN is quietened by setting bit 51, its low 29 bits are cleared, and the class is 5'b10001. If `inv_trap_en` is 1, the operand is returned as is and the class equals `class_in`. For every NaN, `frac_rounded` and `frac_inexact` are 0.
- R4: An in-range finite value keeps 24 significand bits, with LSB at operand bit 29 and guard at bit 28. `rnd_mode` selects the rounding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward +inf and 2'b11 rounds toward -inf. Result bits 28..0 are zero. The class is 5'b00100 for a positive result and 5'b01000 for a negative one.
- R5: `frac_rounded` is 1 exactly when the significand was incremented. `frac_inexact` is the OR of guard, round and sticky. `flags_out[0]` (inexact) ORs in `frac_inexact`.
- R6: If the increment carries out of the 24-bit significand, the exponent goes up by one and the significand becomes 1.0.
- R7: If the rounded exponent exceeds 127 and `ovf_trap_en` is 0, then `flags_out[2]` and `flags_out[0]` are set, `frac_inexact` is 1 and `frac_rounded` is 0. The result is a signed infinity or the largest finite single, ±0x47EFFFFFE0000000. Mode 00 gives infinity. Mode 01 gives the largest finite value. Mode 10 gives +inf for positive operands and the largest finite value for negative ones. Mode 11 gives the mirror case.
- R8: If the rounded exponent exceeds 127 and `ovf_trap_en` is 1, then `flags_out[2]` is set and the rounded value is packed with its exponent reduced by 192.
- R9: A nonzero operand with biased exponent below 897 is tiny. A tiny operand with `unf_trap_en` set raises `flags_out[1]`. Its significand is normalised (this includes double denormals) and rounded, and the value is packed with its exponent increased by 192.
- R10: A tiny operand with `unf_trap_en` clear is shifted right to exponent -126, and the shifted-out bits feed the sticky bit. The value is then rounded. `flags_out[1]` is set only if some bit below the single LSB was nonzero. A zero significand yields a signed zero with the zero class. Any other result is renormalised into the double layout with the normal class. Biased exponent 897 is not tiny.
- R11: The sticky flags `flags_out[3:0]` (invalid-signalling, overflow, underflow, inexact) are `flags_in` ORed with the newly raised ones. An input flag is never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and control inputs are taken this cycle |
| operand | input | 64 | Double-precision source value |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| ovf_trap_en | input | 1 | Overflow trap enable |
| unf_trap_en | input | 1 | Underflow trap enable |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| flags_in | input | 4 | Current sticky flags {invalid-snan, overflow, underflow, inexact} |
| class_in | input | 5 | Current result class code |
| out_valid | output | 1 | Outputs carry a new result |
| result | output | 64 | Rounded value in double layout |
| flags_out | output | 4 | Updated sticky flags |
| frac_rounded | output | 1 | Significand was incremented |
| frac_inexact | output | 1 | Rounded value differs from the operand |
| class_out | output | 5 | Result class code |

## Verification
The clocked properties sample the past cycle's operand and controls whenever `out_valid` is high. They therefore take for granted that the inputs stay stable across the accepting edge and that `out_valid` comes only from an accepted operand. The bench drives every input on the falling edge, raises `in_valid` for exactly one cycle per operand, and samples outputs on the next falling edge. Stimulus stays inside the encodings listed in the requirements: mode values 00 to 11, and class codes from the documented set. Operands are chosen to land precisely on rounding ties, carry-out, overflow and tininess boundaries.

// File: rtl/dbl_to_sgl_round.sv
module dbl_to_sgl_round (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] operand,
  input  logic [1:0]  rnd_mode,
  input  logic        ovf_trap_en,
  input  logic        unf_trap_en,
  input  logic        inv_trap_en,
  input  logic [3:0]  flags_in,
  input  logic [4:0]  class_in,
  output logic        out_valid,
  output logic [63:0] result,
  output logic [3:0]  flags_out,
  output logic        frac_rounded,
  output logic        frac_inexact,
  output logic [4:0]  class_out
);
  localparam logic signed [12:0] EMIN = -13'sd126;
  localparam logic signed [12:0] EMAX = 13'sd127;
  localparam logic signed [12:0] BIAS = 13'sd1023;
  localparam logic signed [12:0] ADJ  = 13'sd192;
  localparam logic [10:0] TINY_LIM = 11'd897;
  localparam logic [4:0] C_QNAN = 5'b10001, C_PINF = 5'b00101, C_NINF = 5'b01001;
  localparam logic [4:0] C_PNORM = 5'b00100, C_NNORM = 5'b01000;
  localparam logic [4:0] C_PZERO = 5'b00010, C_NZERO = 5'b10010;

  function automatic logic [5:0] lead_zeros53(input logic [52:0] v);
    logic [5:0] n;
    logic hit;
    n = '0; hit = 1'b0;
    for (int i = 52; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else n = n + 6'd1;
      end
    end
    return n;
  endfunction

  function automatic logic [4:0] lead_zeros24(input logic [23:0] v);
    logic [4:0] n;
    logic hit;
    n = '0; hit = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else n = n + 5'd1;
      end
    end
    return n;
  endfunction

  function automatic logic [63:0] pack(input logic s, input logic signed [12:0] e, input logic [23:0] m);
    logic [12:0] be;
    be = e + BIAS;
    return {s, be[10:0], m[22:0], 29'b0};
  endfunction

  wire        sgn      = operand[63];
  wire [10:0] bexp     = operand[62:52];
  wire [51:0] frac     = operand[51:0];
  wire        is_zero  = (bexp == 11'd0) && (frac == 52'd0);
  wire        all_ones = (bexp == 11'h7ff);
  wire        is_inf   = all_ones && (frac == 52'd0);
  wire        is_qnan  = all_ones && frac[51];
  wire        is_snan  = all_ones && !frac[51] && (frac != 52'd0);
  wire        tiny     = !is_zero && (bexp < TINY_LIM);
  wire [52:0] sig      = {bexp != 11'd0, frac};
  wire [55:0] wide     = {sig, 3'b000};
  wire signed [12:0] uexp = (bexp == 11'd0) ? -13'sd1022 : $signed({2'b00, bexp}) - BIAS;

  logic [5:0]  nlz;
  logic [52:0] nsig;
  logic signed [12:0] shs;
  logic [55:0] dsh, rv;
  logic        lost, extra;
  logic signed [12:0] rexp, e1;
  logic        lsb, gbit, rbit, xbit, inc;
  logic [24:0] sum;
  logic [23:0] mant, nmant;
  logic [4:0]  tz;
  logic        below;

  always_comb begin
    nlz  = lead_zeros53(sig);
    nsig = sig << nlz;
    shs  = EMIN - uexp;
    if (shs > 13'sd55) begin
      dsh  = '0;
      lost = |sig;
    end else begin
      dsh  = wide >> shs[5:0];
      lost = |(wide & ~({56{1'b1}} << shs[5:0]));
    end
    if (tiny && unf_trap_en) begin
      rv = {nsig, 3'b000}; extra = 1'b0; rexp = uexp - $signed({7'd0, nlz});
    end else if (tiny) begin
      rv = dsh; extra = lost; rexp = EMIN;
    end else begin
      rv = wide; extra = 1'b0; rexp = uexp;
    end
    lsb   = rv[32];
    gbit  = rv[31];
    rbit  = rv[30];
    xbit  = (|rv[29:0]) | extra;
    below = (|rv[31:0]) | extra;
    unique case (rnd_mode)
      2'b00:   inc = gbit & (lsb | rbit | xbit);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !sgn & (gbit | rbit | xbit);
      default: inc = sgn & (gbit | rbit | xbit);
    endcase
    sum = {1'b0, rv[55:32]} + {24'd0, inc};
    if (sum[24]) begin
      mant = sum[24:1]; e1 = rexp + 13'sd1;
    end else begin
      mant = sum[23:0]; e1 = rexp;
    end
    tz    = lead_zeros24(mant);
    nmant = mant << tz;
  end

  logic [63:0] n_res;
  logic [3:0]  n_flags;
  logic        n_fr, n_fi;
  logic [4:0]  n_cls;
  wire  [4:0]  c_norm = sgn ? C_NNORM : C_PNORM;
  wire  [63:0] big_inf = {sgn, 11'h7ff, 52'd0};
  wire  [63:0] big_max = {sgn, 11'h47e, {23{1'b1}}, 29'd0};

  always_comb begin
    n_res = operand; n_flags = flags_in; n_fr = 1'b0; n_fi = 1'b0; n_cls = class_in;
    if (is_zero) begin
      n_cls = sgn ? C_NZERO : C_PZERO;
    end else if (is_inf) begin
      n_cls = sgn ? C_NINF : C_PINF;
    end else if (is_qnan) begin
      n_res = {operand[63:29], 29'd0}; n_cls = C_QNAN;
    end else if (is_snan) begin
      n_flags[3] = 1'b1;
      if (!inv_trap_en) begin
        n_res = {operand[63:52], 1'b1, operand[50:29], 29'd0}; n_cls = C_QNAN;
      end
    end else begin
      n_fr = inc;
      n_fi = gbit | rbit | xbit;
      n_flags[0] = flags_in[0] | n_fi;
      n_cls = c_norm;
      if (tiny && unf_trap_en) begin
        n_flags[1] = 1'b1;
        n_res = pack(sgn, e1 + ADJ, mant);
      end else if (tiny) begin
        n_flags[1] = flags_in[1] | below;
        if (mant == 24'd0) begin
          n_res = {sgn, 63'd0}; n_cls = sgn ? C_NZERO : C_PZERO;
        end else begin
          n_res = pack(sgn, e1 - $signed({8'd0, tz}), nmant);
        end
      end else if (e1 > EMAX) begin
        n_flags[2] = 1'b1;
        if (ovf_trap_en) begin
          n_res = pack(sgn, e1 - ADJ, mant);
        end else begin
          n_fr = 1'b0; n_fi = 1'b1; n_flags[0] = 1'b1;
          unique case (rnd_mode)
            2'b00:   n_res = big_inf;
            2'b01:   n_res = big_max;
            2'b10:   n_res = sgn ? big_max : big_inf;
            default: n_res = sgn ? big_inf : big_max;
          endcase
          if (n_res[62:52] == 11'h7ff) n_cls = sgn ? C_NINF : C_PINF;
        end
      end else begin
        n_res = pack(sgn, e1, mant);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0; flags_out <= '0;
      frac_rounded <= 1'b0; frac_inexact <= 1'b0; class_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= n_res; flags_out <= n_flags;
        frac_rounded <= n_fr; frac_inexact <= n_fi; class_out <= n_cls;
      end
    end
  end

  p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((flags_out & $past(flags_in)) == $past(flags_in)));
  p_low_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[62:52] != 11'h7ff) |-> (result[28:0] == 29'd0));
  p_fr_needs_fi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && frac_rounded) |-> frac_inexact);
  p_special_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(operand[51:0] == 52'd0 && (operand[62:52] == 11'd0 || operand[62:52] == 11'h7ff)))
      |-> (result == $past(operand) && !frac_rounded && !frac_inexact));
  p_snan_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(operand[62:52] == 11'h7ff && !operand[51] && operand[50:0] != 51'd0)) |-> flags_out[3]);
  p_ovf_nearest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(operand[62:52] > 11'd1150 && operand[62:52] != 11'h7ff && !ovf_trap_en && rnd_mode == 2'b00))
      |-> (result[62:0] == {11'h7ff, 52'd0} && flags_out[2]));
endmodule

// File: tb/dbl_to_sgl_round_test.sv
module dbl_to_sgl_round_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  rnd_mode = '0;
  logic        ovf_trap_en = 1'b0, unf_trap_en = 1'b0, inv_trap_en = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [4:0]  class_in = '0;
  logic        out_valid, frac_rounded, frac_inexact;
  logic [63:0] result;
  logic [3:0]  flags_out;
  logic [4:0]  class_out;
  int total = 0;
  int bad = 0;

  dbl_to_sgl_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand), .rnd_mode(rnd_mode),
    .ovf_trap_en(ovf_trap_en), .unf_trap_en(unf_trap_en), .inv_trap_en(inv_trap_en),
    .flags_in(flags_in), .class_in(class_in), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .frac_rounded(frac_rounded), .frac_inexact(frac_inexact),
    .class_out(class_out));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic apply(input logic [63:0] op, input logic [1:0] m, input logic oe, input logic ue,
                       input logic ve, input logic [3:0] fl, input logic [4:0] cl);
    @(negedge clk);
    operand = op; rnd_mode = m; ovf_trap_en = oe; unf_trap_en = ue; inv_trap_en = ve;
    flags_in = fl; class_in = cl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [63:0] er, input logic [3:0] ef,
                            input logic efr, input logic efi, input logic [4:0] ec);
    total++;
    if (!out_valid || result !== er || flags_out !== ef || frac_rounded !== efr ||
        frac_inexact !== efi || class_out !== ec) begin
      bad++;
      $display("FAIL %s: got v=%b res=%h fl=%b fr=%b fi=%b cls=%b, expected v=1 res=%h fl=%b fr=%b fi=%b cls=%b",
               req, out_valid, result, flags_out, frac_rounded, frac_inexact, class_out,
               er, ef, efr, efi, ec);
    end
  endtask

  task automatic t_reset;
    total++;
    if (out_valid !== 1'b0 || result !== 64'd0 || flags_out !== 4'd0 || class_out !== 5'd0 ||
        frac_rounded !== 1'b0 || frac_inexact !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got v=%b res=%h fl=%b cls=%b, expected all zero",
               out_valid, result, flags_out, class_out);
    end
  endtask

  task automatic t_latency;
    apply(64'h3FF0000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R1 one-cycle result", 64'h3FF0000000000000, 4'b0000, 0, 0, 5'b00100);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== 64'h3FF0000000000000) begin
      bad++;
      $display("FAIL R1 idle: got v=%b res=%h, expected v=0 res=3ff0000000000000", out_valid, result);
    end
  endtask

  task automatic t_specials;
    apply(64'h0000000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R2 +zero", 64'h0, 4'b0000, 0, 0, 5'b00010);
    apply(64'h8000000000000000, 2'b10, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R2 -zero", 64'h8000000000000000, 4'b0000, 0, 0, 5'b10010);
    apply(64'hFFF0000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R2 -inf", 64'hFFF0000000000000, 4'b0000, 0, 0, 5'b01001);
    apply(64'h7FF0000000000000, 2'b01, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R2 +inf", 64'h7FF0000000000000, 4'b0000, 0, 0, 5'b00101);
  endtask

  task automatic t_nans;
    apply(64'h7FF80001F2345678, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R3 qnan", 64'h7FF80001E0000000, 4'b0000, 0, 0, 5'b10001);
    apply(64'h7FF0000000000001, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R3 snan quieted", 64'h7FF8000000000000, 4'b1000, 0, 0, 5'b10001);
    apply(64'h7FF0000000000001, 2'b00, 0, 0, 1, 4'd0, 5'b00100);
    expect_out("R3 snan trap", 64'h7FF0000000000001, 4'b1000, 0, 0, 5'b00100);
  endtask

  task automatic t_rounding;
    apply(64'h3FF0000010000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R4 R5 nearest tie even", 64'h3FF0000000000000, 4'b0001, 0, 1, 5'b00100);
    apply(64'h3FF0000010000000, 2'b10, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R4 R5 toward +inf", 64'h3FF0000020000000, 4'b0001, 1, 1, 5'b00100);
    apply(64'h3FF0000010000000, 2'b01, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R4 toward zero", 64'h3FF0000000000000, 4'b0001, 0, 1, 5'b00100);
    apply(64'hBFF0000010000000, 2'b11, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R4 toward -inf neg", 64'hBFF0000020000000, 4'b0001, 1, 1, 5'b01000);
    apply(64'hBFF0000010000000, 2'b10, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R4 toward +inf neg", 64'hBFF0000000000000, 4'b0001, 0, 1, 5'b01000);
    apply(64'h3FF0000030000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R4 nearest tie odd", 64'h3FF0000040000000, 4'b0001, 1, 1, 5'b00100);
    apply(64'h3FFFFFFFF0000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R6 carry out", 64'h4000000000000000, 4'b0001, 1, 1, 5'b00100);
  endtask

  task automatic t_overflow;
    apply(64'h47F0000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R7 nearest inf", 64'h7FF0000000000000, 4'b0101, 0, 1, 5'b00101);
    apply(64'h47F0000000000000, 2'b01, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R7 toward zero max", 64'h47EFFFFFE0000000, 4'b0101, 0, 1, 5'b00100);
    apply(64'hC7F0000000000000, 2'b10, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R7 +inf mode neg", 64'hC7EFFFFFE0000000, 4'b0101, 0, 1, 5'b01000);
    apply(64'hC7F0000000000000, 2'b11, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R7 -inf mode neg", 64'hFFF0000000000000, 4'b0101, 0, 1, 5'b01001);
    apply(64'h47EFFFFFF0000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R6 R7 overflow by rounding", 64'h7FF0000000000000, 4'b0101, 0, 1, 5'b00101);
    apply(64'h47F0000000000000, 2'b00, 1, 0, 0, 4'd0, 5'd0);
    expect_out("R8 trap exact", 64'h3BF0000000000000, 4'b0100, 0, 0, 5'b00100);
    apply(64'h47F0000010000000, 2'b00, 1, 0, 0, 4'd0, 5'd0);
    expect_out("R8 trap inexact", 64'h3BF0000000000000, 4'b0101, 0, 1, 5'b00100);
  endtask

  task automatic t_underflow;
    apply(64'h3800000000000000, 2'b00, 0, 1, 0, 4'd0, 5'd0);
    expect_out("R9 trap normal", 64'h4400000000000000, 4'b0010, 0, 0, 5'b00100);
    apply(64'h0000000000000001, 2'b00, 0, 1, 0, 4'd0, 5'd0);
    expect_out("R9 trap double denormal", 64'h08D0000000000000, 4'b0010, 0, 0, 5'b00100);
    apply(64'h3800000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R10 exact tiny", 64'h3800000000000000, 4'b0000, 0, 0, 5'b00100);
    apply(64'h3800000000000001, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R10 inexact tiny", 64'h3800000000000000, 4'b0011, 0, 1, 5'b00100);
    apply(64'h3370000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R10 flush +zero", 64'h0, 4'b0011, 0, 1, 5'b00010);
    apply(64'hB370000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R10 flush -zero", 64'h8000000000000000, 4'b0011, 0, 1, 5'b10010);
    apply(64'h3370000000000000, 2'b10, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R10 round up to min denormal", 64'h36A0000000000000, 4'b0011, 1, 1, 5'b00100);
    apply(64'h3810000000000000, 2'b00, 0, 0, 0, 4'd0, 5'd0);
    expect_out("R10 boundary not tiny", 64'h3810000000000000, 4'b0000, 0, 0, 5'b00100);
  endtask

  task automatic t_sticky;
    apply(64'h3FF0000000000000, 2'b00, 0, 0, 0, 4'b1111, 5'd0);
    expect_out("R11 flags kept", 64'h3FF0000000000000, 4'b1111, 0, 0, 5'b00100);
    apply(64'h7FF8000000000000, 2'b00, 0, 0, 0, 4'b0110, 5'd0);
    expect_out("R11 flags kept on nan", 64'h7FF8000000000000, 4'b0110, 0, 0, 5'b10001);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_specials();
    t_nans();
    t_rounding();
    t_overflow();
    t_underflow();
    t_sticky();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule